// File: doc/BRIEF.md
# Adaptive Pass-Voltage Tuning Controller

This controller picks, for every block of a flash array, the lowest pass-through voltage code that keeps the read errors it causes within the ECC's spare correction margin. A lower pass voltage slows read-disturb damage, but it also causes sensing errors. The controller searches in two phases. A coarse descent goes past the ECC limit, then a fine ascent returns under it. It stores the winning code in a per-block table, and that table also holds each block's worst-case page.

A daily tick starts a tuning pass that visits every block. Each trial read goes to that block's worst page through a request/response flash port. The response carries the error count that the external ECC decoder reports. Between passes the same port serves normal host reads at the block's stored code. A read that fails ECC is reissued at a higher code. When it still fails at the maximum code, the read is flagged uncorrectable. A refresh of a block returns that block to the conservative maximum code. Voltage generation, the array and the decoder all sit outside the block.

Top module: `vpass_tuner`

## Requirements
- R1: After reset, a clearing sweep sets every block's code to 63 and its worst page to 0. `busy` is high for the NBLK cycles of the sweep and low afterwards.
- R2: A `day_tick` pulse starts a pass that visits blocks 0 to NBLK-1 in ascending order. `busy` stays high for the whole pass. A pending host read is held and completes only after `busy` falls.
- R3: The first trial for a block reads its stored worst page at code 63, and that error count is the block's base count. If the base count is at least `ecc_limit`, the block keeps code 63 and gets no further trial.
- R4: The spare margin is `ecc_limit` minus the base count. The descent lowers the code by 4 per trial for as long as the trial's error count stays at or below `ecc_limit`, which means the extra errors fit the spare margin.
- R5: After the first trial that exceeds `ecc_limit`, the code rises by 1 per trial. The first code that fits, or code 63, is saved for the block.
- R6: The descent is clamped at code 51. If a trial at 51 fits, 51 is saved. No flash request ever carries a code below 51 or above 63.
- R7: A host read is issued to the host's page at the block's stored code. If its error count is at or below `ecc_limit`, `rd_done` pulses with `rd_uncorr` = 0 and `rd_code_used` set to that code.
- R8: A failing host read is retried at the code plus 4, clamped to 63. If the read still fails at 63, `rd_done` pulses with `rd_uncorr` = 1 and `rd_code_used` = 63, and no further request is made.
- R9: A host worst-page write (`host_wr_en`) is ignored while `busy` is high. When `busy` is low the write is accepted, and the next pass uses the new page.
- R10: A `refresh_valid` pulse sets the named block's stored code back to 63.
- R11: Only one flash request is outstanding at a time. Each request is a single-cycle pulse, and the next request waits for the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| day_tick | input | 1 | Starts a tuning pass over all blocks |
| ecc_limit | input | ERR_W | Correction limit of the ECC, in errors |
| refresh_valid | input | 1 | Block refreshed: restore its default code |
| refresh_blk | input | BLK_W | Refreshed block number |
| host_wr_en | input | 1 | Write a worst-page index |
| host_wr_blk | input | BLK_W | Block for the worst-page write |
| host_wr_page | input | PAGE_W | Worst-page index to store |
| rd_req | input | 1 | Host read request, held until `rd_done` |
| rd_blk | input | BLK_W | Host read block |
| rd_page | input | PAGE_W | Host read page |
| rd_done | output | 1 | Host read finished (one-cycle pulse) |
| rd_uncorr | output | 1 | Host read failed even at the maximum code |
| rd_code_used | output | CODE_W | Code of the final read attempt |
| busy | output | 1 | Clearing sweep or tuning pass in progress |
| fl_req | output | 1 | Flash read request pulse |
| fl_blk | output | BLK_W | Flash read block |
| fl_page | output | PAGE_W | Flash read page |
| fl_code | output | CODE_W | Pass-voltage code for this read |
| fl_rsp_valid | input | 1 | Flash/ECC response valid |
| fl_err_cnt | input | ERR_W | Error count that the ECC reports for the read |

## Verification
The hardest state to reach from the ports is the fine ascent after an overshoot. It needs a block whose induced errors climb steeply just below code 63, and it has to end exactly at the first code that fits. The bench's flash model gives every block its own base error count, knee code and slope. These vary enough that some blocks skip the search, some settle on the floor and some overshoot and climb back. A second pass runs with a smaller limit to imitate a shrinking margin. After that, a very low limit forces host reads through the retry chain up to the uncorrectable flag.

// File: rtl/vpass_pkg.sv
package vpass_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_T_ADDR,
    ST_T_BASE,
    ST_T_BWAIT,
    ST_T_DOWN,
    ST_T_UP,
    ST_T_SAVE,
    ST_T_NEXT,
    ST_R_ADDR,
    ST_R_ISSUE,
    ST_R_WAIT
  } vpass_state_e;

endpackage

// File: rtl/vpass_table.sv
module vpass_table #(
  parameter int NBLK   = 256,
  parameter int CODE_W = 6,
  parameter int PAGE_W = 8,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              code_we,
  input  logic [BLK_W-1:0]  code_waddr,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              page_we,
  input  logic [BLK_W-1:0]  page_waddr,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic [BLK_W-1:0]  raddr,
  output logic [CODE_W-1:0] rcode,
  output logic [PAGE_W-1:0] rpage
);

  // two simple-dual-port arrays so each maps onto its own block RAM
  logic [CODE_W-1:0] code_mem [NBLK];
  logic [PAGE_W-1:0] page_mem [NBLK];

  always_ff @(posedge clk) begin
    if (code_we) code_mem[code_waddr] <= code_wdata;
    rcode <= code_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (page_we) page_mem[page_waddr] <= page_wdata;
    rpage <= page_mem[raddr];
  end

endmodule

// File: rtl/vpass_code_step.sv
module vpass_code_step #(
  parameter int CODE_W      = 6,
  parameter int CODE_MAX    = 63,
  parameter int CODE_FLOOR  = 51,
  parameter int STEP_COARSE = 4,
  parameter int STEP_FINE   = 1,
  parameter int STEP_RETRY  = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] dn_coarse,
  output logic [CODE_W-1:0] up_fine,
  output logic [CODE_W-1:0] up_retry,
  output logic              at_floor,
  output logic              at_max
);

  localparam logic [CODE_W-1:0] MAXV   = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] FLOORV = CODE_W'(CODE_FLOOR);

  always_comb begin
    if (int'(code) >= CODE_FLOOR + STEP_COARSE) dn_coarse = code - CODE_W'(STEP_COARSE);
    else                                        dn_coarse = FLOORV;
    if (int'(code) + STEP_FINE <= CODE_MAX) up_fine = code + CODE_W'(STEP_FINE);
    else                                    up_fine = MAXV;
  end

  assign at_floor = (code <= FLOORV);
  assign at_max   = (code >= MAXV);

  // a zero retry step selects a direct jump to the maximum code
  generate
    if (STEP_RETRY == 0) begin : g_retry_jump
      assign up_retry = MAXV;
    end else begin : g_retry_step
      always_comb begin
        if (int'(code) + STEP_RETRY <= CODE_MAX) up_retry = code + CODE_W'(STEP_RETRY);
        else                                     up_retry = MAXV;
      end
    end
  endgenerate

endmodule

// File: rtl/vpass_tuner.sv
module vpass_tuner
  import vpass_pkg::*;
#(
  parameter int NBLK        = 256,
  parameter int CODE_W      = 6,
  parameter int PAGE_W      = 8,
  parameter int ERR_W       = 8,
  parameter int CODE_MAX    = 63,
  parameter int CODE_FLOOR  = 51,
  parameter int STEP_COARSE = 4,
  parameter int STEP_FINE   = 1,
  parameter int STEP_RETRY  = 4,
  localparam int BLK_W      = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              day_tick,
  input  logic [ERR_W-1:0]  ecc_limit,
  input  logic              refresh_valid,
  input  logic [BLK_W-1:0]  refresh_blk,
  input  logic              host_wr_en,
  input  logic [BLK_W-1:0]  host_wr_blk,
  input  logic [PAGE_W-1:0] host_wr_page,
  input  logic              rd_req,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [PAGE_W-1:0] rd_page,
  output logic              rd_done,
  output logic              rd_uncorr,
  output logic [CODE_W-1:0] rd_code_used,
  output logic              busy,
  output logic              fl_req,
  output logic [BLK_W-1:0]  fl_blk,
  output logic [PAGE_W-1:0] fl_page,
  output logic [CODE_W-1:0] fl_code,
  input  logic              fl_rsp_valid,
  input  logic [ERR_W-1:0]  fl_err_cnt
);

  localparam logic [CODE_W-1:0] MAXV     = CODE_W'(CODE_MAX);
  localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(NBLK - 1);

  vpass_state_e      state;
  logic [BLK_W-1:0]  cur_blk;
  logic [CODE_W-1:0] code;
  logic [ERR_W-1:0]  base_err;
  logic [ERR_W-1:0]  spare;
  logic              tick_pend;

  // table ports
  logic              code_we;
  logic [BLK_W-1:0]  code_waddr;
  logic [CODE_W-1:0] code_wdata;
  logic              page_we;
  logic [BLK_W-1:0]  page_waddr;
  logic [PAGE_W-1:0] page_wdata;
  logic [BLK_W-1:0]  tbl_raddr;
  logic [CODE_W-1:0] tbl_code;
  logic [PAGE_W-1:0] tbl_page;

  // code stepping
  logic [CODE_W-1:0] dn_coarse, up_fine, up_retry;
  logic              at_floor, at_max;

  // margin check against the spare ECC capability
  logic [ERR_W-1:0]  induced;
  logic              fits;
  logic              exceeds_limit;

  assign induced       = (fl_err_cnt > base_err) ? (fl_err_cnt - base_err) : '0;
  assign fits          = (induced <= spare);
  assign exceeds_limit = (fl_err_cnt > ecc_limit);

  vpass_code_step #(
    .CODE_W     (CODE_W),
    .CODE_MAX   (CODE_MAX),
    .CODE_FLOOR (CODE_FLOOR),
    .STEP_COARSE(STEP_COARSE),
    .STEP_FINE  (STEP_FINE),
    .STEP_RETRY (STEP_RETRY)
  ) u_step (
    .code     (code),
    .dn_coarse(dn_coarse),
    .up_fine  (up_fine),
    .up_retry (up_retry),
    .at_floor (at_floor),
    .at_max   (at_max)
  );

  vpass_table #(
    .NBLK  (NBLK),
    .CODE_W(CODE_W),
    .PAGE_W(PAGE_W)
  ) u_table (
    .clk       (clk),
    .code_we   (code_we),
    .code_waddr(code_waddr),
    .code_wdata(code_wdata),
    .page_we   (page_we),
    .page_waddr(page_waddr),
    .page_wdata(page_wdata),
    .raddr     (tbl_raddr),
    .rcode     (tbl_code),
    .rpage     (tbl_page)
  );

  assign tbl_raddr = (state == ST_T_ADDR) ? cur_blk : rd_blk;

  // code-table write port: sweep, then refresh, then tuning result
  always_comb begin
    code_we    = 1'b0;
    code_waddr = cur_blk;
    code_wdata = MAXV;
    if (state == ST_INIT) begin
      code_we = 1'b1;
    end else if (refresh_valid) begin
      code_we    = 1'b1;
      code_waddr = refresh_blk;
    end else if (state == ST_T_SAVE) begin
      code_we    = 1'b1;
      code_wdata = code;
    end
  end

  // page-table write port: sweep, or host writes outside a pass
  always_comb begin
    page_we    = 1'b0;
    page_waddr = cur_blk;
    page_wdata = '0;
    if (state == ST_INIT) begin
      page_we = 1'b1;
    end else if (host_wr_en && !busy) begin
      page_we    = 1'b1;
      page_waddr = host_wr_blk;
      page_wdata = host_wr_page;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_INIT;
      cur_blk      <= '0;
      code         <= MAXV;
      base_err     <= '0;
      spare        <= '0;
      tick_pend    <= 1'b0;
      busy         <= 1'b1;
      fl_req       <= 1'b0;
      fl_blk       <= '0;
      fl_page      <= '0;
      fl_code      <= MAXV;
      rd_done      <= 1'b0;
      rd_uncorr    <= 1'b0;
      rd_code_used <= MAXV;
    end else begin
      fl_req    <= 1'b0;
      rd_done   <= 1'b0;
      tick_pend <= tick_pend | day_tick;
      unique case (state)
        ST_INIT: begin
          if (cur_blk == LAST_BLK) begin
            cur_blk <= '0;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            cur_blk <= cur_blk + 1'b1;
          end
        end
        ST_IDLE: begin
          if (tick_pend) begin
            tick_pend <= 1'b0;
            busy      <= 1'b1;
            cur_blk   <= '0;
            state     <= ST_T_ADDR;
          end else if (rd_req) begin
            state <= ST_R_ADDR;
          end
        end
        ST_T_ADDR: state <= ST_T_BASE;
        ST_T_BASE: begin
          code    <= MAXV;
          fl_req  <= 1'b1;
          fl_blk  <= cur_blk;
          fl_page <= tbl_page;
          fl_code <= MAXV;
          state   <= ST_T_BWAIT;
        end
        ST_T_BWAIT: begin
          if (fl_rsp_valid) begin
            base_err <= fl_err_cnt;
            if (fl_err_cnt >= ecc_limit) begin
              state <= ST_T_SAVE;
            end else begin
              spare   <= ecc_limit - fl_err_cnt;
              code    <= dn_coarse;
              fl_req  <= 1'b1;
              fl_code <= dn_coarse;
              state   <= ST_T_DOWN;
            end
          end
        end
        ST_T_DOWN: begin
          if (fl_rsp_valid) begin
            if (!fits) begin
              code    <= up_fine;
              fl_req  <= 1'b1;
              fl_code <= up_fine;
              state   <= ST_T_UP;
            end else if (at_floor) begin
              state <= ST_T_SAVE;
            end else begin
              code    <= dn_coarse;
              fl_req  <= 1'b1;
              fl_code <= dn_coarse;
            end
          end
        end
        ST_T_UP: begin
          if (fl_rsp_valid) begin
            if (fits || at_max) begin
              state <= ST_T_SAVE;
            end else begin
              code    <= up_fine;
              fl_req  <= 1'b1;
              fl_code <= up_fine;
            end
          end
        end
        ST_T_SAVE: begin
          if (!refresh_valid) state <= ST_T_NEXT;
        end
        ST_T_NEXT: begin
          if (cur_blk == LAST_BLK) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            cur_blk <= cur_blk + 1'b1;
            state   <= ST_T_ADDR;
          end
        end
        ST_R_ADDR: state <= ST_R_ISSUE;
        ST_R_ISSUE: begin
          code    <= tbl_code;
          fl_req  <= 1'b1;
          fl_blk  <= rd_blk;
          fl_page <= rd_page;
          fl_code <= tbl_code;
          state   <= ST_R_WAIT;
        end
        ST_R_WAIT: begin
          if (fl_rsp_valid) begin
            if (!exceeds_limit || at_max) begin
              rd_done      <= 1'b1;
              rd_uncorr    <= exceeds_limit;
              rd_code_used <= code;
              state        <= ST_IDLE;
            end else begin
              code    <= up_retry;
              fl_req  <= 1'b1;
              fl_code <= up_retry;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vpass_tuner_chk.sv
module vpass_tuner_chk #(
  parameter int CODE_W     = 6,
  parameter int CODE_MAX   = 63,
  parameter int CODE_FLOOR = 51
) (
  input logic              clk,
  input logic              rst,
  input logic              fl_req,
  input logic [CODE_W-1:0] fl_code,
  input logic              fl_rsp_valid,
  input logic              rd_done,
  input logic              rd_uncorr,
  input logic [CODE_W-1:0] rd_code_used,
  input logic              busy
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst)               outstanding <= 1'b0;
    else if (fl_req)       outstanding <= 1'b1;
    else if (fl_rsp_valid) outstanding <= 1'b0;
  end

  AST_CODE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> (int'(fl_code) >= CODE_FLOOR && int'(fl_code) <= CODE_MAX)); // R6

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fl_req |=> !fl_req); // R11

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> !outstanding); // R11

  AST_UNCORR_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    (rd_done && rd_uncorr) |-> (int'(rd_code_used) == CODE_MAX)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done); // R7

  AST_NO_READ_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_done); // R2

endmodule

bind vpass_tuner vpass_tuner_chk #(
  .CODE_W    (CODE_W),
  .CODE_MAX  (CODE_MAX),
  .CODE_FLOOR(CODE_FLOOR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fl_req      (fl_req),
  .fl_code     (fl_code),
  .fl_rsp_valid(fl_rsp_valid),
  .rd_done     (rd_done),
  .rd_uncorr   (rd_uncorr),
  .rd_code_used(rd_code_used),
  .busy        (busy)
);

// File: tb/vpass_tuner_bench.sv
`timescale 1ns/1ps
module vpass_tuner_bench;

  localparam int NBLK  = 256;
  localparam int CMAX  = 63;
  localparam int CFLR  = 51;

  logic       clk = 1'b0;
  logic       rst;
  logic       day_tick;
  logic [7:0] ecc_limit;
  logic       refresh_valid;
  logic [7:0] refresh_blk;
  logic       host_wr_en;
  logic [7:0] host_wr_blk;
  logic [7:0] host_wr_page;
  logic       rd_req;
  logic [7:0] rd_blk;
  logic [7:0] rd_page;
  logic       rd_done;
  logic       rd_uncorr;
  logic [5:0] rd_code_used;
  logic       busy;
  logic       fl_req;
  logic [7:0] fl_blk;
  logic [7:0] fl_page;
  logic [5:0] fl_code;
  logic       fl_rsp_valid = 1'b0;
  logic [7:0] fl_err_cnt = '0;

  vpass_tuner u_vpass_tuner (
    .clk(clk), .rst(rst), .day_tick(day_tick), .ecc_limit(ecc_limit),
    .refresh_valid(refresh_valid), .refresh_blk(refresh_blk),
    .host_wr_en(host_wr_en), .host_wr_blk(host_wr_blk), .host_wr_page(host_wr_page),
    .rd_req(rd_req), .rd_blk(rd_blk), .rd_page(rd_page),
    .rd_done(rd_done), .rd_uncorr(rd_uncorr), .rd_code_used(rd_code_used),
    .busy(busy), .fl_req(fl_req), .fl_blk(fl_blk), .fl_page(fl_page),
    .fl_code(fl_code), .fl_rsp_valid(fl_rsp_valid), .fl_err_cnt(fl_err_cnt)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // per-pass logs, filled by the flash model
  int trials [NBLK];
  int first_code [NBLK];
  int last_code [NBLK];
  int first_page [NBLK];
  int exp_blk, order_err, overlap;
  int rd_n, rd_first;
  int done_in_busy = 0;

  // bench-side model of the table
  int exp_code [NBLK];
  int page_model [NBLK];
  int cat_cnt [3];

  // flash error model: base errors, knee code, slope per block
  function automatic int f_base(int b); return (b * 7 + 2) % 13; endfunction
  function automatic int f_thr(int b);  return 50 + (b * 5) % 14; endfunction
  function automatic int f_err(int b, int c);
    int t = f_thr(b);
    return f_base(b) + ((c < t) ? (t - c) * (1 + b % 3) : 0);
  endfunction

  // expected search outcome (R3..R6); cat 0 skip, 1 floor, 2 ascent
  function automatic void exp_tune(input int b, input int lim,
                                   output int code, output int n, output int cat);
    int c, nc;
    bit fin;
    n = 1; code = CMAX; cat = 0;
    if (f_base(b) >= lim) return;
    c = CMAX; fin = 1'b0;
    while (!fin) begin
      nc = (c - 4 >= CFLR) ? c - 4 : CFLR;
      n++;
      if (f_err(b, nc) > lim) begin
        c = nc;
        do begin c++; n++; end while (f_err(b, c) > lim && c != CMAX);
        code = c; cat = 2; fin = 1'b1;
      end else if (nc == CFLR) begin
        code = CFLR; cat = 1; fin = 1'b1;
      end else begin
        c = nc;
      end
    end
  endfunction

  // expected host read outcome (R7, R8)
  function automatic void exp_read(input int b, input int s, input int lim,
                                   output int used, output int unc, output int n);
    int c = s;
    n = 1;
    while (f_err(b, c) > lim && c != CMAX) begin
      c = (c + 4 > CMAX) ? CMAX : c + 4;
      n++;
    end
    used = c;
    unc  = (f_err(b, c) > lim) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // flash + ECC model: answers two negedges after each request
  int pend = 0, dly = 0, p_blk = 0, p_code = 0;
  always @(negedge clk) begin
    fl_rsp_valid = 1'b0;
    if (pend != 0) begin
      dly--;
      if (dly == 0) begin
        fl_rsp_valid = 1'b1;
        fl_err_cnt   = 8'(f_err(p_blk, p_code));
        pend = 0;
      end
    end
    if (!rst && fl_req) begin
      if (pend != 0) overlap++;
      pend = 1; dly = 2; p_blk = int'(fl_blk); p_code = int'(fl_code);
      if (busy) begin
        if (trials[p_blk] == 0) begin
          first_page[p_blk] = int'(fl_page);
          first_code[p_blk] = p_code;
          if (p_blk != exp_blk) order_err++;
          exp_blk++;
        end
        trials[p_blk]++;
        last_code[p_blk] = p_code;
      end else begin
        rd_n++;
        if (rd_n == 1) rd_first = p_code;
      end
    end
    if (!rst && busy && rd_done) done_in_busy++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic clear_logs();
    for (int b = 0; b < NBLK; b++) begin
      trials[b] = 0; first_code[b] = -1; last_code[b] = -1; first_page[b] = -1;
    end
    exp_blk = 0; order_err = 0;
  endtask

  task automatic host_write(input int b, input int pg);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_blk = 8'(b); host_wr_page = 8'(pg);
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic do_refresh(input int b);
    @(negedge clk);
    refresh_valid = 1'b1; refresh_blk = 8'(b);
    @(negedge clk);
    refresh_valid = 1'b0;
  endtask

  // host read with full check against the model
  task automatic read_chk(input int b, input string tag);
    int used, unc, n;
    exp_read(b, exp_code[b], int'(ecc_limit), used, unc, n);
    @(negedge clk);
    rd_n = 0; rd_first = -1;
    rd_req = 1'b1; rd_blk = 8'(b); rd_page = 8'($urandom % 256);
    do @(negedge clk); while (!rd_done);
    rd_req = 1'b0;
    chk(rd_first == exp_code[b], tag, "first read code", rd_first, exp_code[b]);
    chk(int'(rd_code_used) == used && int'(rd_uncorr) == unc && rd_n == n, tag,
        "read final code/uncorr/attempts", int'(rd_code_used) * 100 + int'(rd_uncorr) * 10 + rd_n,
        used * 100 + unc * 10 + n);
  endtask

  task automatic start_pass(input int lim);
    clear_logs();
    ecc_limit = 8'(lim);
    @(negedge clk);
    day_tick = 1'b1;
    @(negedge clk);
    day_tick = 1'b0;
    while (!busy) @(negedge clk);
  endtask

  task automatic finish_pass(input int lim);
    int ec, en, cat;
    int bad_first, bad_page;
    string tag;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(order_err == 0 && exp_blk == NBLK, "R2", "blocks visited in order",
        exp_blk - order_err, NBLK);
    bad_first = 0; bad_page = 0;
    for (int b = 0; b < NBLK; b++) begin
      if (first_code[b] != CMAX) bad_first++;
      if (first_page[b] != page_model[b]) bad_page++;
      exp_tune(b, lim, ec, en, cat);
      cat_cnt[cat]++;
      tag = (cat == 0) ? "R3" : (cat == 1) ? "R4/R6" : "R4/R5";
      chk(trials[b] == en && last_code[b] == ec, tag, $sformatf("block %0d saved code", b),
          last_code[b] * 100 + trials[b], ec * 100 + en);
      exp_code[b] = ec;
    end
    chk(bad_first == 0, "R3", "first trial at max code", bad_first, 0);
    chk(bad_page == 0, "R9", "trials on stored worst page", bad_page, 0);
  endtask

  initial begin
    int b, cycles;
    void'($urandom(32'd7311));
    rst = 1'b1; day_tick = 1'b0; ecc_limit = 8'd10; refresh_valid = 1'b0;
    refresh_blk = '0; host_wr_en = 1'b0; host_wr_blk = '0; host_wr_page = '0;
    rd_req = 1'b0; rd_blk = '0; rd_page = '0; overlap = 0;
    for (int i = 0; i < NBLK; i++) begin exp_code[i] = CMAX; page_model[i] = 0; end
    for (int i = 0; i < 3; i++) cat_cnt[i] = 0;
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: clearing sweep
    chk(busy == 1'b1 && fl_req == 1'b0 && rd_done == 1'b0, "R1", "state after reset",
        int'(busy), 1);
    cycles = 0;
    while (busy) begin @(negedge clk); cycles++; end
    chk(cycles >= NBLK && cycles <= NBLK + 2, "R1", "sweep length", cycles, NBLK);
    for (int i = 0; i < 4; i++) read_chk(int'($urandom % NBLK), "R1");

    // R9: host page writes while idle
    for (int i = 0; i < 16; i++) begin
      b = int'($urandom % NBLK);
      page_model[b] = int'($urandom % 256);
      host_write(b, page_model[b]);
    end
    host_write(250, 8'h10); page_model[250] = 8'h10;

    // pass 1, with a write attempt during busy (R9)
    start_pass(10);
    host_write(250, 8'hAB);
    chk(busy == 1'b1, "R2", "busy during pass", int'(busy), 1);
    finish_pass(10);
    chk(cat_cnt[0] > 0 && cat_cnt[1] > 0 && cat_cnt[2] > 0, "R5",
        "skip/floor/ascent cases all reached", cat_cnt[0] * cat_cnt[1] * cat_cnt[2], 1);

    // R7/R8: random reads at the tuned codes
    for (int i = 0; i < 24; i++) read_chk(int'($urandom % NBLK), "R7");

    host_write(250, 8'h77); page_model[250] = 8'h77;

    // pass 2 with a smaller margin and a read held behind it (R2)
    start_pass(6);
    @(negedge clk);
    rd_n = 0; rd_first = -1; done_in_busy = 0;
    rd_req = 1'b1; rd_blk = 8'd9; rd_page = 8'd3;
    finish_pass(6);
    while (!rd_done) @(negedge clk);
    rd_req = 1'b0;
    chk(done_in_busy == 0, "R2", "read completed during pass", done_in_busy, 0);
    chk(rd_first == exp_code[9], "R2", "held read used new code", rd_first, exp_code[9]);

    // R10: refresh restores the default
    for (int i = 0; i < NBLK; i++) begin
      if (exp_code[i] < CMAX && i != 9) begin b = i; break; end
    end
    do_refresh(b);
    exp_code[b] = CMAX;
    read_chk(b, "R10");
    do_refresh(14);
    exp_code[14] = CMAX;
    read_chk(14, "R10");

    // R8: tight limit forces retries and uncorrectable reads
    ecc_limit = 8'd3;
    read_chk(11, "R8");
    read_chk(28, "R8");
    for (int i = 0; i < 20; i++) read_chk(int'($urandom % NBLK), "R8");

    chk(overlap == 0, "R11", "overlapping flash requests", overlap, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule